// File: doc/BRIEF.md
# Serial Converter Sample Capture Controller

This block is the master side of a three-wire serial link to a 12-bit successive-approximation converter. Each time the system raises a sample request, the controller drops the converter's active-low select line, waits a setup delay, and runs a burst of serial clocks. The first two rising clock edges give the converter time to acquire its input. The bit sampled on the third rising edge is a leading zero, which the controller checks and then drops. The twelve bits that follow are shifted in most significant bit first and delivered as one straight-binary word with a one-cycle valid pulse.

After the last clock the select line goes high and stays high for a minimum recovery time. All serial timing comes from the system clock through counters whose limits are parameters: half-period, setup delay and recovery delay. Elaboration rejects any setting that breaks the converter's minimum high/low time, setup time or recovery time. It also rejects a serial clock slow enough to let the held sample decay (below about 10 kHz).

The clock polarity at rest is a parameter, which covers both of the clock modes the converter accepts. A request that arrives during a frame or during the recovery time is held and served as soon as the recovery time ends. The sample rate is set by whatever strobe drives the request input.

Top module: `adc_sample_ctrl`

## Requirements
- R1: While reset is held and after its release until the first request, `cs_n` is 1, `busy` is 0, `result_vld` is 0, `null_err` is 0 and `result` is zero.
- R2: When a request is accepted, `cs_n` falls, and no `sclk` transition occurs until `cs_n` has been low for at least SETUP_CYC system cycles.
- R3: Every frame contains exactly PRE_CLKS+1+DATA_W rising `sclk` edges (15 by default). Between the first and last transition of a frame, every `sclk` level lasts exactly HALF_CYC system cycles.
- R4: Whenever `cs_n` is high, `sclk` rests at the level CPOL: 0 gives clock mode 0 (first frame edge rising), 1 gives mode 3 (first frame edge falling).
- R5: `sdi` is sampled only at rising `sclk` edges. The bits at the first two rising edges of a frame are ignored. The bits at rising edges 4 through 15 form `result`, with the 4th edge giving `result[11]` and the 15th giving `result[0]`, straight binary with no sign handling.
- R6: `result` and `result_vld` change only at the system clock edge that produces the final rising `sclk` edge of a frame. `result_vld` is then high for exactly one cycle, once per frame, and `result` holds its value until the next frame completes.
- R7: `null_err`, updated together with `result`, is 1 if `sdi` was high at the 3rd rising edge of that frame, and 0 if it was low.
- R8: Between two frames `cs_n` stays high for at least IDLE_CYC system cycles. When a request is waiting, the next frame starts after exactly IDLE_CYC cycles.
- R9: A request that arrives while a frame or the recovery time is in progress is kept as one pending request. Any number of such requests together produce exactly one further frame.
- R10: `busy` is 1 from the cycle after a request is accepted until the recovery time of the last frame ends, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_req | input | 1 | Sample request strobe, one cycle or longer |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to the converter |
| sdi | input | 1 | Serial data from the converter |
| result | output | DATA_W (12) | Last captured conversion word |
| result_vld | output | 1 | One-cycle pulse when `result` is updated |
| null_err | output | 1 | Leading bit of the last frame was not zero |
| busy | output | 1 | A frame or its recovery time is in progress |

## Verification
A wrong bit counter shows up within one frame: the number of rising edges between select falling and rising changes, and every captured word shifts by one bit position. A converter model drives ones during the acquisition clocks, which exposes such a shift at once. A bad half-period or delay counter breaks the measured level lengths, the setup lead or the recovery gap at the very next frame. A lost or duplicated pending request changes how many valid pulses appear after a back-to-back burst, and this is visible as soon as the following recovery time ends.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

   // Frame sequencer states
   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_SETUP = 2'd1,
      CAP_SHIFT = 2'd2,
      CAP_HOLD  = 2'd3
   } cap_state_e;

   function automatic int cap_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/adc_cap_timer.sv
// Cycle counter: asserts done on the limit-th consecutive cycle of run.
module adc_cap_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign done = run && (cnt_q == (limit - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || done) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/adc_cap_sclk.sv
// Serial clock level, transition count and rising-edge index.
module adc_cap_sclk #(
   parameter bit CPOL  = 1'b0,
   parameter int RISES = 15,
   parameter int RW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic          sclk,
   output logic          rise,
   output logic [RW-1:0] rise_idx,
   output logic          last
);
   localparam logic [RW-1:0] ONE    = RW'(1);
   localparam logic [RW-1:0] LAST_E = RW'(2 * RISES);

   logic          idle_lvl;
   logic          sclk_q;
   logic [RW-1:0] edge_q;
   logic [RW-1:0] rise_q;

   generate
      if (CPOL) begin : g_idle_high
         assign idle_lvl = 1'b1;
      end else begin : g_idle_low
         assign idle_lvl = 1'b0;
      end
   endgenerate

   assign sclk     = sclk_q;
   assign rise     = step && !sclk_q;
   assign rise_idx = rise_q;
   assign last     = (edge_q == LAST_E);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= CPOL;
         edge_q <= '0;
         rise_q <= '0;
      end else if (clr) begin
         sclk_q <= idle_lvl;
         edge_q <= '0;
         rise_q <= '0;
      end else if (step) begin
         sclk_q <= ~sclk_q;
         edge_q <= edge_q + ONE;
         if (rise) begin
            rise_q <= rise_q + ONE;
         end
      end
   end
endmodule

// File: rtl/adc_cap_shift.sv
// Capture path: drops acquisition bits, checks the null bit, assembles the word.
module adc_cap_shift #(
   parameter int DATA_W = 12,
   parameter int PRE    = 2,
   parameter int RW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              sdi,
   input  logic [RW-1:0]     idx,
   output logic [DATA_W-1:0] result,
   output logic              result_vld,
   output logic              null_err
);
   localparam logic [RW-1:0] NULL_IDX = RW'(PRE);
   localparam logic [RW-1:0] LAST_IDX = RW'(PRE + DATA_W);

   logic [DATA_W-2:0] sh_q;
   logic              null_q;
   logic              is_data;

   assign is_data = (idx > NULL_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         null_q     <= 1'b0;
         result     <= '0;
         result_vld <= 1'b0;
         null_err   <= 1'b0;
      end else begin
         result_vld <= 1'b0;
         if (sample) begin
            if (idx == NULL_IDX) begin
               null_q <= sdi;
            end
            if (is_data) begin
               sh_q <= {sh_q[DATA_W-3:0], sdi};
            end
            if (idx == LAST_IDX) begin
               result     <= {sh_q, sdi};
               result_vld <= 1'b1;
               null_err   <= null_q;
            end
         end
      end
   end
endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl #(
   parameter int CLK_NS       = 8,
   parameter int HALF_CYC     = 40,
   parameter int SETUP_CYC    = 13,
   parameter int IDLE_CYC     = 79,
   parameter bit CPOL         = 1'b0,
   parameter int DATA_W       = 12,
   parameter int PRE_CLKS     = 2,
   parameter int MIN_HALF_NS  = 312,
   parameter int MIN_SETUP_NS = 100,
   parameter int MIN_IDLE_NS  = 625,
   parameter int MAX_SCLK_NS  = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_req,
   output logic              cs_n,
   output logic              sclk,
   input  logic              sdi,
   output logic [DATA_W-1:0] result,
   output logic              result_vld,
   output logic              null_err,
   output logic              busy
);
   import adc_cap_pkg::*;

   localparam int FRAME_RISES = PRE_CLKS + 1 + DATA_W;
   localparam int RW          = $clog2(2 * FRAME_RISES + 1);
   localparam int TMAX        = cap_max3(HALF_CYC, SETUP_CYC, IDLE_CYC);
   localparam int TW          = $clog2(TMAX + 1);
   localparam logic [TW-1:0] HALF_L  = TW'(HALF_CYC);
   localparam logic [TW-1:0] SETUP_L = TW'(SETUP_CYC);
   localparam logic [TW-1:0] IDLE_L  = TW'(IDLE_CYC);

   // Elaboration-time parameter checks
   generate
      if (HALF_CYC * CLK_NS < MIN_HALF_NS) begin : g_bad_half
         $error("serial clock high/low time below minimum");
      end
      if (2 * HALF_CYC * CLK_NS > MAX_SCLK_NS) begin : g_bad_slow
         $error("serial clock too slow, held sample would decay");
      end
      if (SETUP_CYC * CLK_NS < MIN_SETUP_NS) begin : g_bad_setup
         $error("select-to-clock setup below minimum");
      end
      if (IDLE_CYC * CLK_NS < MIN_IDLE_NS) begin : g_bad_idle
         $error("select recovery time below minimum");
      end
      if (DATA_W < 3 || PRE_CLKS < 0) begin : g_bad_frame
         $error("unsupported frame shape");
      end
   endgenerate

   cap_state_e    st_q, st_d;
   logic          pend_q;
   logic          cs_q;
   logic          want;
   logic          accept;
   logic          phase_run, phase_done;
   logic [TW-1:0] phase_lim;
   logic          half_run, half_done;
   logic          sclk_clr, sclk_step, sclk_rise, sclk_last;
   logic [RW-1:0] rise_idx;

   assign want = sample_req | pend_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CAP_IDLE:  if (want) st_d = CAP_SETUP;
         CAP_SETUP: if (phase_done) st_d = CAP_SHIFT;
         CAP_SHIFT: if (half_done && sclk_last) st_d = CAP_HOLD;
         CAP_HOLD:  if (phase_done) st_d = want ? CAP_SETUP : CAP_IDLE;
         default:   st_d = CAP_IDLE;
      endcase
   end

   assign accept = (st_d == CAP_SETUP) && ((st_q == CAP_IDLE) || (st_q == CAP_HOLD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CAP_IDLE;
         pend_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         st_q <= st_d;
         cs_q <= !((st_d == CAP_SETUP) || (st_d == CAP_SHIFT));
         if (accept) begin
            pend_q <= 1'b0;
         end else if (sample_req && (st_q != CAP_IDLE)) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign phase_run = (st_q == CAP_SETUP) || (st_q == CAP_HOLD);
   assign phase_lim = (st_q == CAP_SETUP) ? SETUP_L : IDLE_L;
   assign half_run  = (st_q == CAP_SHIFT);
   assign sclk_clr  = (st_q != CAP_SHIFT);
   assign sclk_step = half_done && !sclk_last;

   adc_cap_timer #(.CNT_W(TW)) u_phase_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (phase_run),
      .limit (phase_lim),
      .done  (phase_done)
   );

   adc_cap_timer #(.CNT_W(TW)) u_half_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (half_run),
      .limit (HALF_L),
      .done  (half_done)
   );

   adc_cap_sclk #(.CPOL(CPOL), .RISES(FRAME_RISES), .RW(RW)) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sclk_clr),
      .step     (sclk_step),
      .sclk     (sclk),
      .rise     (sclk_rise),
      .rise_idx (rise_idx),
      .last     (sclk_last)
   );

   adc_cap_shift #(.DATA_W(DATA_W), .PRE(PRE_CLKS), .RW(RW)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample     (sclk_rise),
      .sdi        (sdi),
      .idx        (rise_idx),
      .result     (result),
      .result_vld (result_vld),
      .null_err   (null_err)
   );

   assign cs_n = cs_q;
   assign busy = (st_q != CAP_IDLE);
endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk #(
   parameter bit CPOL      = 1'b0,
   parameter int HALF_CYC  = 40,
   parameter int SETUP_CYC = 13,
   parameter int IDLE_CYC  = 79,
   parameter int DATA_W    = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sclk,
   input logic              busy,
   input logic [DATA_W-1:0] result,
   input logic              result_vld
);
   localparam int SAT = 1 << 20;

   logic sclk_q;
   int   lvl_cnt;
   int   hi_cnt;
   int   lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= CPOL;
         lvl_cnt <= HALF_CYC;
         hi_cnt  <= IDLE_CYC;
         lo_cnt  <= 0;
      end else begin
         sclk_q  <= sclk;
         lvl_cnt <= (sclk != sclk_q) ? 1 : ((lvl_cnt < SAT) ? lvl_cnt + 1 : lvl_cnt);
         hi_cnt  <= cs_n ? ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt) : 0;
         lo_cnt  <= !cs_n ? ((lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt) : 0;
      end
   end

   // R4
   sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sclk == CPOL));

   // R3
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk != sclk_q) |-> (lvl_cnt >= HALF_CYC));

   // R2
   setup_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sclk != sclk_q) && !cs_n) |-> (lo_cnt >= SETUP_CYC));

   // R8
   cs_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= IDLE_CYC));

   // R10
   busy_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   // R6
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |=> !result_vld);

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> result_vld);
endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk #(
   .CPOL      (CPOL),
   .HALF_CYC  (HALF_CYC),
   .SETUP_CYC (SETUP_CYC),
   .IDLE_CYC  (IDLE_CYC),
   .DATA_W    (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .sclk       (sclk),
   .busy       (busy),
   .result     (result),
   .result_vld (result_vld)
);

// File: tb/adc_sample_ctrl_tb_top.sv
// Behavioural converter: bit chosen by the number of rising edges seen in the frame.
module adc_cap_conv_model (
   input  logic        cs_n,
   input  logic        sclk,
   input  logic [11:0] code,
   input  logic        null_bad,
   output logic        sdo
);
   int rises = 0;

   always @(posedge sclk or posedge cs_n) begin
      if (cs_n) rises <= 0;
      else      rises <= rises + 1;
   end

   always_comb begin
      if (rises < 2)        sdo = 1'b1;          // acquisition clocks: junk ones
      else if (rises == 2)  sdo = null_bad;      // leading null bit
      else if (rises < 15)  sdo = code[14 - rises];
      else                  sdo = 1'b0;
   end
endmodule

// Timing monitor sampled away from the active edge.
module adc_cap_mon (
   input  logic clk,
   input  logic cs_n,
   input  logic sclk,
   output int   lead_last,
   output int   gap_last,
   output int   rises_last,
   output int   minrun
);
   int   gap = 0, lead = 0, run = 0, rises = 0;
   logic seen = 1'b0, cs_d = 1'b1, sck_d = 1'b0, init = 1'b0;

   initial begin
      lead_last = 0; gap_last = 0; rises_last = 0; minrun = 1 << 20;
   end

   always @(negedge clk) begin
      if (!init) begin
         init = 1'b1;
      end else if (cs_n) begin
         if (!cs_d) rises_last = rises;
         gap++;
      end else begin
         if (cs_d) begin
            gap_last = gap; gap = 0; lead = 0; seen = 1'b0; rises = 0; run = 0;
         end
         if (sclk != sck_d) begin
            if (!seen) lead_last = lead;
            else if (run < minrun) minrun = run;
            seen = 1'b1; run = 1;
            if (sclk) rises++;
         end else begin
            run++;
            if (!seen) lead++;
         end
      end
      cs_d  = cs_n;
      sck_d = sclk;
   end
endmodule

module adc_sample_ctrl_tb_top;
   localparam int HALF  = 40;
   localparam int SETUP = 13;
   localparam int IDLE  = 79;
   localparam int NVEC  = 8;
   // {null bit driven, 12-bit code}
   localparam logic [12:0] VEC [NVEC] = '{
      13'h0000, 13'h0FFF, 13'h0800, 13'h07FF,
      13'h0001, 13'h1A5A, 13'h0C3C, 13'h1000
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic [11:0] code = '0;
   logic null_bad = 1'b0;

   always #4 clk = ~clk;

   logic cs0, sck0, sd0, vld0, ne0, busy0;
   logic cs3, sck3, sd3, vld3, ne3, busy3;
   logic [11:0] res0, res3;

   adc_sample_ctrl #(.CLK_NS(8), .HALF_CYC(HALF), .SETUP_CYC(SETUP), .IDLE_CYC(IDLE), .CPOL(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_req(req), .cs_n(cs0), .sclk(sck0), .sdi(sd0),
      .result(res0), .result_vld(vld0), .null_err(ne0), .busy(busy0));

   adc_sample_ctrl #(.CLK_NS(8), .HALF_CYC(HALF), .SETUP_CYC(SETUP), .IDLE_CYC(IDLE), .CPOL(1'b1)) dut3_i (
      .clk(clk), .rst_n(rst_n), .sample_req(req), .cs_n(cs3), .sclk(sck3), .sdi(sd3),
      .result(res3), .result_vld(vld3), .null_err(ne3), .busy(busy3));

   adc_cap_conv_model m0_i (.cs_n(cs0), .sclk(sck0), .code(code), .null_bad(null_bad), .sdo(sd0));
   adc_cap_conv_model m3_i (.cs_n(cs3), .sclk(sck3), .code(code), .null_bad(null_bad), .sdo(sd3));

   int lead0, gap0, rises0, minrun0;
   int lead3, gap3, rises3, minrun3;
   adc_cap_mon mon0_i (.clk(clk), .cs_n(cs0), .sclk(sck0), .lead_last(lead0), .gap_last(gap0),
                       .rises_last(rises0), .minrun(minrun0));
   adc_cap_mon mon3_i (.clk(clk), .cs_n(cs3), .sclk(sck3), .lead_last(lead3), .gap_last(gap3),
                       .rises_last(rises3), .minrun(minrun3));

   int vcnt0 = 0, vcnt3 = 0;
   logic [11:0] cap0 = '0, cap3 = '0;
   logic capne0 = 1'b0, capne3 = 1'b0;

   always @(negedge clk) begin
      if (vld0) begin vcnt0++; cap0 = res0; capne0 = ne0; end
      if (vld3) begin vcnt3++; cap3 = res3; capne3 = ne3; end
   end

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_req();
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
   endtask

   task automatic wait_vld(input int target);
      int t = 0;
      while ((vcnt0 < target || vcnt3 < target) && t < 20000) begin
         @(negedge clk); t++;
      end
   endtask

   task automatic wait_idle();
      int t = 0;
      while ((busy0 || busy3) && t < 20000) begin
         @(negedge clk); t++;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 / R4: reset state, both modes
      check(cs0 == 1'b1 && cs3 == 1'b1, "R1 cs_n in reset", int'(cs0), 1);
      check(busy0 == 1'b0 && busy3 == 1'b0, "R1 busy in reset", int'(busy0), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(vld0 == 1'b0 && vld3 == 1'b0, "R1 result_vld after reset", int'(vld0), 0);
      check(res0 == 12'd0 && res3 == 12'd0, "R1 result after reset", int'(res0), 0);
      check(ne0 == 1'b0 && ne3 == 1'b0, "R1 null_err after reset", int'(ne0), 0);
      check(sck0 == 1'b0, "R4 mode 0 rest level", int'(sck0), 0);
      check(sck3 == 1'b1, "R4 mode 3 rest level", int'(sck3), 1);

      // Vector table: R5, R7, R6
      for (int i = 0; i < NVEC; i++) begin
         {null_bad, code} = VEC[i];
         pulse_req();
         wait_vld(i + 1);
         check(cap0 == code, "R5 mode 0 word", int'(cap0), int'(code));
         check(cap3 == code, "R5 mode 3 word", int'(cap3), int'(code));
         check(capne0 == null_bad && capne3 == null_bad, "R7 null flag", int'(capne0), int'(null_bad));
         check(busy0 == 1'b1, "R10 busy during recovery", int'(busy0), 1);
         wait_idle();
         repeat (20) @(negedge clk);
         check(res0 == code && res3 == code, "R6 result held", int'(res0), int'(code));
         check(vcnt0 == i + 1 && vcnt3 == i + 1, "R6 one pulse per frame", vcnt0, i + 1);
      end

      // Frame shape and timing
      check(rises0 == 15, "R3 rising edges mode 0", rises0, 15);
      check(rises3 == 15, "R3 rising edges mode 3", rises3, 15);
      check(minrun0 == HALF, "R3 level length mode 0", minrun0, HALF);
      check(minrun3 == HALF, "R3 level length mode 3", minrun3, HALF);
      check(lead0 >= SETUP, "R2 setup lead mode 0", lead0, SETUP);
      check(lead3 >= SETUP, "R2 setup lead mode 3", lead3, SETUP);
      check(sck0 == 1'b0 && sck3 == 1'b1, "R4 rest level after frames", int'(sck0), 0);
      check(busy0 == 1'b0 && busy3 == 1'b0, "R10 busy clear when idle", int'(busy0), 0);

      // Pending requests collapse to one frame: R9, R8, R10
      begin
         int base;
         base = vcnt0;
         code = 12'h5A3; null_bad = 1'b0;
         pulse_req();
         repeat (200) @(negedge clk);
         check(busy0 == 1'b1 && busy3 == 1'b1, "R10 busy inside frame", int'(busy0), 1);
         pulse_req();
         pulse_req();
         pulse_req();
         wait_vld(base + 2);
         wait_idle();
         repeat (3000) @(negedge clk);
         check(vcnt0 == base + 2, "R9 pending collapse mode 0", vcnt0, base + 2);
         check(vcnt3 == base + 2, "R9 pending collapse mode 3", vcnt3, base + 2);
         check(gap0 == IDLE, "R8 recovery gap mode 0", gap0, IDLE);
         check(gap3 == IDLE, "R8 recovery gap mode 3", gap3, IDLE);
         check(cap0 == 12'h5A3 && cap3 == 12'h5A3, "R5 back-to-back word", int'(cap0), 'h5A3);
         check(busy0 == 1'b0 && cs0 == 1'b1, "R10 idle after burst", int'(busy0), 0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule